// File: doc/BRIEF.md
# Four-Phase Handshake Bus Initiator

This block is the requesting side of a small parallel bus. Address, command and data travel on plain wires, and one active-low request line and one active-low acknowledge line pace each transfer. A local agent hands the block one read or write command at a time through a valid/ready command port. The block registers the command and drives the address, the command bit and, for writes, the data. It holds them for a programmable number of local clock cycles and only then pulls the request line low.

After that the block follows the four-phase handshake. It waits for the target to pull acknowledge low, and on a read it samples the data bus at that point. It then raises request and stops driving all bus outputs. It waits for the target to let acknowledge go high again, and only then reports completion through a one-cycle response pulse. Acknowledge arrives from another timing domain, so it passes through a two-flop synchronizer before the controller uses it. A watchdog counter can end a request that receives no acknowledge, and it flags the response as an error.

Bus outputs are modelled as values plus output-enable signals. The bus can therefore be shared with other drivers through external three-state buffers.

Top module: `hsbus_initiator`

## Requirements
- R1: While rst_ni is low: bus_req_no is 1, bus_addr_oe_o and bus_data_oe_o are 0, and rsp_valid_o is 0. After reset release, cmd_ready_o is 1.
- R2: A command is accepted only on a clock edge where cmd_ready_o and cmd_valid_i are both 1. cmd_ready_o is 1 only while the block is idle. A cmd_valid_i asserted while a transfer is in flight starts no bus transfer and produces no response.
- R3: After acceptance, bus_addr_o carries the address and bus_cmd_o carries the command (0 = read, 1 = write), with bus_addr_oe_o at 1. For a write, bus_data_o carries the write data with bus_data_oe_o at 1; for a read, bus_data_oe_o stays 0. bus_req_no falls only after exactly SETUP_CYC cycles with this setup driven.
- R4: Once bus_req_no is low, it stays low, and bus_addr_o and bus_cmd_o stay stable, until the synchronized acknowledge is seen low or the timeout expires.
- R5: On a read, bus_data_i is sampled in the cycle the synchronized acknowledge is first seen low. The sampled value is returned on rsp_rdata_o with the completion pulse.
- R6: In the cycle after the low acknowledge is seen, bus_req_no is back at 1, and bus_addr_oe_o and bus_data_oe_o are both 0.
- R7: rsp_valid_o pulses for exactly one cycle, and only after the synchronized acknowledge has returned high. In the following cycle, cmd_ready_o is 1 again.
- R8: If acknowledge is not seen low within TIMEOUT_CYC cycles of request low (TIMEOUT_CYC > 0), the block releases the bus as in R6. It then completes with rsp_err_o at 1. bus_req_no is never low for more than TIMEOUT_CYC consecutive cycles.
- R9: An acknowledge that is first seen low in the last allowed request cycle completes the transfer normally, with rsp_err_o at 0 and valid read data.
- R10: bus_ack_ni passes through two flops before it is used. If acknowledge goes low in request-low cycle j, counting from 0, then bus_req_no stays low for j+3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command can be taken |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | AW | Target address |
| cmd_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_err_o | output | 1 | Completion ended by timeout |
| rsp_rdata_o | output | DW | Data returned by the last read |
| bus_addr_o | output | AW | Address lines value |
| bus_cmd_o | output | 1 | Command line value |
| bus_addr_oe_o | output | 1 | Enable for address and command lines |
| bus_data_o | output | DW | Data lines value for writes |
| bus_data_oe_o | output | 1 | Enable for data lines |
| bus_data_i | input | DW | Data lines as seen on the bus |
| bus_req_no | output | 1 | Request, active low |
| bus_ack_ni | input | 1 | Acknowledge from target, active low, asynchronous |

## Verification
A synchronized acknowledge can first show low in the same cycle that the timeout counter reaches its limit. That is the one place where a normal completion and an abort compete. The bench's target model delays its acknowledge by TIMEOUT_CYC-3 request cycles, so that after the two synchronizer flops the low value arrives in the final allowed cycle. The scoreboard then expects a clean read with the right data. With a delay one cycle longer, it expects an error response.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_REQ,
    ST_RELEASE,
    ST_DONE
  } hs_state_e;
endpackage

// File: rtl/hsbus_sync.sv
module hsbus_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/hsbus_cycle_cnt.sv
// Counts enabled cycles; hit_o marks the MAX-th enabled cycle.
module hsbus_cycle_cnt #(
  parameter int MAX = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int CW = (MAX > 1) ? $clog2(MAX) : 1;

  logic [CW-1:0] cnt_q;

  assign hit_o = en_i && (cnt_q == CW'(MAX - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (en_i && !hit_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hsbus_initiator.sv
module hsbus_initiator
  import hsbus_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int SETUP_CYC   = 2,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic          cmd_write_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_cmd_o,
  output logic          bus_addr_oe_o,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_oe_o,
  input  logic [DW-1:0] bus_data_i,
  output logic          bus_req_no,
  input  logic          bus_ack_ni
);
  hs_state_e     state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          wr_q, err_q;
  logic          ack_n_s;
  logic          setup_hit, to_hit;

  hsbus_sync #(.STAGES(2), .RST_VAL(1'b1)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_ack_ni),
    .q_o   (ack_n_s)
  );

  hsbus_cycle_cnt #(.MAX(SETUP_CYC)) u_setup_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q != ST_SETUP),
    .en_i  (state_q == ST_SETUP),
    .hit_o (setup_hit)
  );

  generate
    if (TIMEOUT_CYC > 0) begin : g_timeout
      hsbus_cycle_cnt #(.MAX(TIMEOUT_CYC)) u_to_cnt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (state_q != ST_REQ),
        .en_i  (state_q == ST_REQ),
        .hit_o (to_hit)
      );
    end else begin : g_no_timeout
      assign to_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (cmd_valid_i) state_d = ST_SETUP;
      ST_SETUP:   if (setup_hit)   state_d = ST_REQ;
      // a low ack wins over a timeout in the same cycle
      ST_REQ:     if (!ack_n_s || to_hit) state_d = ST_RELEASE;
      ST_RELEASE: if (ack_n_s)     state_d = ST_DONE;
      ST_DONE:                     state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && cmd_valid_i) begin
        addr_q  <= cmd_addr_i;
        wdata_q <= cmd_wdata_i;
        wr_q    <= cmd_write_i;
        err_q   <= 1'b0;
      end
      if (state_q == ST_REQ) begin
        if (!ack_n_s) begin
          if (!wr_q) rdata_q <= bus_data_i;
        end else if (to_hit) begin
          err_q <= 1'b1;
        end
      end
    end
  end

  logic drive;
  assign drive         = (state_q == ST_SETUP) || (state_q == ST_REQ);
  assign cmd_ready_o   = (state_q == ST_IDLE);
  assign rsp_valid_o   = (state_q == ST_DONE);
  assign rsp_err_o     = err_q;
  assign rsp_rdata_o   = rdata_q;
  assign bus_addr_o    = addr_q;
  assign bus_cmd_o     = wr_q;
  assign bus_addr_oe_o = drive;
  assign bus_data_o    = wdata_q;
  assign bus_data_oe_o = drive && wr_q;
  assign bus_req_no    = (state_q != ST_REQ);
endmodule

// File: rtl/hsbus_initiator_chk.sv
module hsbus_initiator_chk #(
  parameter int AW          = 8,
  parameter int TIMEOUT_CYC = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_ready_o,
  input logic          rsp_valid_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_cmd_o,
  input logic          bus_addr_oe_o,
  input logic          bus_data_oe_o,
  input logic          bus_req_no
);
  logic [15:0] req_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    req_low_cnt <= '0;
    else if (bus_req_no)            req_low_cnt <= '0;
    else if (req_low_cnt != '1)     req_low_cnt <= req_low_cnt + 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (bus_req_no && !bus_addr_oe_o && !rsp_valid_o)); // R2
  AST_REQ_WITH_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_no |-> bus_addr_oe_o); // R3
  AST_SETUP_BEFORE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_req_no) |-> $past(bus_addr_oe_o)); // R3
  AST_DATA_OE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_data_oe_o |-> (bus_addr_oe_o && bus_cmd_o)); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_req_no && !$past(bus_req_no)) |-> ($stable(bus_addr_o) && $stable(bus_cmd_o))); // R4
  AST_RELEASE_DROPS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_no) |-> (!bus_addr_oe_o && !bus_data_oe_o)); // R6
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R7
  AST_RSP_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (bus_req_no && !bus_addr_oe_o)); // R7
  AST_REQ_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_req_no && TIMEOUT_CYC > 0) |-> (req_low_cnt < 16'(TIMEOUT_CYC))); // R8
endmodule

bind hsbus_initiator hsbus_initiator_chk #(.AW(AW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_ready_o  (cmd_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .bus_addr_o   (bus_addr_o),
  .bus_cmd_o    (bus_cmd_o),
  .bus_addr_oe_o(bus_addr_oe_o),
  .bus_data_oe_o(bus_data_oe_o),
  .bus_req_no   (bus_req_no)
);

// File: tb/hsbus_initiator_bench.sv
module hsbus_initiator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int SETUP = 2;
  localparam int TO = 16;

  typedef struct { bit err; bit wr; logic [7:0] rdata; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata, bus_data_o, tdata = '0;
  logic [AW-1:0] bus_addr;
  logic bus_cmd, addr_oe, data_oe, req_n;
  logic ack_n = 1'b1;

  int checks = 0, fails = 0;
  exp_t sb_q[$];
  logic [7:0] exp_addr, exp_wdata;
  bit exp_wr;
  int t_delay = 0, t_wait = 0, setup_seen = 0, req_low = 0, exp_req_low = 0;
  int txn_cnt = 0;
  bit prev_req_low = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsbus_initiator #(.AW(AW), .DW(DW), .SETUP_CYC(SETUP), .TIMEOUT_CYC(TO)) u_hsbus_initiator (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_write_i(cmd_write),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .bus_addr_o(bus_addr), .bus_cmd_o(bus_cmd), .bus_addr_oe_o(addr_oe),
    .bus_data_o(bus_data_o), .bus_data_oe_o(data_oe), .bus_data_i(tdata),
    .bus_req_no(req_n), .bus_ack_ni(ack_n)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Target model and bus-timing monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (addr_oe && req_n) setup_seen++;
      else if (!addr_oe) setup_seen = 0;
      if (!req_n) begin
        if (!prev_req_low) begin
          txn_cnt++;
          t_wait = 0;
          req_low = 0;
          chk(setup_seen == SETUP, "R3", "setup cycles", setup_seen, SETUP);
          chk(bus_addr == exp_addr, "R3", "address", int'(bus_addr), int'(exp_addr));
          chk(bus_cmd == exp_wr, "R3", "command", int'(bus_cmd), int'(exp_wr));
          chk(data_oe == exp_wr, "R3", "data enable", int'(data_oe), int'(exp_wr));
          if (exp_wr) chk(bus_data_o == exp_wdata, "R3", "write data", int'(bus_data_o), int'(exp_wdata));
        end
        req_low++;
        if (ack_n) begin
          if (t_wait == t_delay) begin
            ack_n = 1'b0;
            tdata = bus_addr ^ 8'hA5;
          end
          t_wait++;
        end
      end else begin
        if (prev_req_low) begin
          chk(!addr_oe && !data_oe, "R6", "enables after release", int'({addr_oe, data_oe}), 0);
          chk(req_low == exp_req_low, "R10", "request low cycles", req_low, exp_req_low);
        end
        if (!ack_n) ack_n = 1'b1;
      end
      prev_req_low = !req_n;
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      chk(ack_n == 1'b1, "R7", "ack high at response", int'(ack_n), 1);
      if (sb_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rsp_err == e.err, e.err ? "R8" : "R9", "error flag", int'(rsp_err), int'(e.err));
        if (!e.wr && !e.err) chk(rsp_rdata == e.rdata, "R5", "read data", int'(rsp_rdata), int'(e.rdata));
      end
    end
  end

  task automatic run_txn(bit wr, logic [7:0] a, logic [7:0] wd, int dly, bit err);
    exp_t e;
    while (!cmd_ready) @(negedge clk);
    exp_addr = a; exp_wdata = wd; exp_wr = wr; t_delay = dly;
    exp_req_low = err ? TO : dly + 3;
    e.err = err; e.wr = wr; e.rdata = a ^ 8'hA5;
    sb_q.push_back(e);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (sb_q.size() != 0) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R7", "ready after response", int'(cmd_ready), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    chk(req_n == 1'b1, "R1", "req in reset", int'(req_n), 1);
    chk(!addr_oe && !data_oe, "R1", "enables in reset", int'({addr_oe, data_oe}), 0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "ready after reset", int'(cmd_ready), 1);

    run_txn(1'b0, 8'h24, 8'h00, 0, 1'b0);
    run_txn(1'b1, 8'h31, 8'hF4, 3, 1'b0);
    run_txn(1'b0, 8'h04, 8'h00, 5, 1'b0);
    run_txn(1'b1, 8'hC0, 8'h3C, 1, 1'b0);

    // R2: command offered while busy must be ignored
    n0 = txn_cnt;
    fork
      run_txn(1'b0, 8'h5A, 8'h00, 8, 1'b0);
      begin
        repeat (3) @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 8'h77; cmd_wdata = 8'h11;
        repeat (4) @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    repeat (10) @(negedge clk);
    chk(txn_cnt == n0 + 1, "R2", "bus transfers", txn_cnt - n0, 1);
    chk(sb_q.size() == 0, "R2", "pending responses", sb_q.size(), 0);

    // R8: no acknowledge -> abort
    run_txn(1'b0, 8'h10, 8'h00, 1000, 1'b1);
    // R9: ack seen in last allowed cycle wins
    run_txn(1'b0, 8'h6B, 8'h00, TO - 3, 1'b0);
    // one cycle later: timeout wins
    run_txn(1'b1, 8'h6C, 8'h99, TO - 2, 1'b1);
    run_txn(1'b0, 8'hFF, 8'h00, 2, 1'b0);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule